// File: doc/BRIEF.md
# Bus Machine-Cycle Sequencer

This block steps through the bus activity of a small set of instructions for a classic 8-bit processor. A caller presents a decoded instruction class, plus the condition outcome for a conditional call, and pulses `start` while the block is idle. From the next clock on, the block walks through the instruction's machine cycles one T-state per clock. For each T-state it reports which kind of bus cycle is running and the T-state number within it. It also drives the I/O-versus-memory status line and the active-low read and write strobes.

The sequence for each instruction class comes from a step table. The opcode fetch lasts four or six T-states, depending on whether the instruction does internal 16-bit work. Every other bus cycle lasts three T-states. A conditional call whose condition is false ends after its first operand read. A one-clock `done` pulse marks the final T-state. The block then returns to idle and can take the next class on the following clock.

Top module: `mcyc_seq`

## Requirements
- R1: While reset is applied and after it is released, the block is idle. In idle, `mcyc_type`=0 (idle), `tstate`=0, `io_m`=0, `rd_n`=1, `wr_n`=1, `done`=0 and `busy`=0.
- R2: `start` is sampled on a rising edge only while idle. The opcode fetch at T1 is visible in the clock period that follows that edge. Cycle type codes are 1 opcode fetch, 2 memory read, 3 memory write, 4 I/O read, 5 I/O write.
- R3: The opcode fetch lasts 6 T-states for classes 2 (pair decrement), 3 (pair push), 4 (call) and 5 (conditional call). It lasts 4 T-states for classes 0 (register-only), 1 (load immediate), 6 (port input) and 7 (port output).
- R4: The cycle sequence of each class is as follows:
  - class 0: fetch.
  - class 1: fetch, memory read.
  - class 2: fetch.
  - class 3: fetch, memory write, memory write.
  - class 4: fetch, memory read, memory read, memory write, memory write.
  - class 6: fetch, memory read, I/O read.
  - class 7: fetch, memory read, I/O write.
- R5: The total T-states per class are 4, 7, 6, 12, 18, 9 or 18, 10 and 10, for classes 0 through 7.
- R6: Class 5 with `cond`=0 ends after fetch and one memory read, for 9 T-states. With `cond`=1 it follows the class-4 sequence. `cond` is captured only with `start`; later changes have no effect.
- R7: `io_m` is 1 exactly during I/O read and I/O write cycles, and 0 otherwise.
- R8: `rd_n` is 0 only in T2 and T3 of fetch, memory read and I/O read cycles. `wr_n` is 0 only in T2 and T3 of memory write and I/O write cycles. The two strobes are never low together.
- R9: T-states count up from 1, one per clock, within a cycle. Every non-fetch cycle lasts 3 T-states.
- R10: `done` is high for exactly one clock, in the last T-state of the last cycle, and the block is idle on the next clock. A `start` or a new class presented while busy is ignored.
- R11: Asserting `rst_n` during an instruction returns the block to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an instruction (sampled while idle) |
| instr_cls | input | 3 | Decoded instruction class |
| cond | input | 1 | Condition outcome for the conditional call |
| mcyc_type | output | 3 | Current cycle type (0 idle) |
| tstate | output | 3 | Current T-state number (0 idle) |
| io_m | output | 1 | High for I/O cycles, low for memory cycles |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | Final T-state of the instruction |
| busy | output | 1 | An instruction is in progress |

## Verification
All outputs decode combinationally from the state registers. A `start` taken at an edge therefore shows T1 of the fetch in the very next clock period. Every later T-state appears one clock after the one before it, and the idle state appears one clock after `done`.

The bench drives inputs and samples outputs on the falling edge, so each check falls one clock per expected T-state. It sweeps every class with both condition values while holding a conflicting `start`, class and condition during the run.

The internal reset release adds two edges of delay, and the bench waits past them before it drives anything.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int CLS_W   = 3;
  localparam int KIND_W  = 3;
  localparam int T_W     = 3;
  localparam int IDX_W   = 3;

  localparam int FETCH_SHORT = 4;
  localparam int FETCH_LONG  = 6;
  localparam int BUS_LEN     = 3;

  typedef enum logic [KIND_W-1:0] {
    MC_IDLE = 3'd0,
    MC_OF   = 3'd1,
    MC_MR   = 3'd2,
    MC_MW   = 3'd3,
    MC_IOR  = 3'd4,
    MC_IOW  = 3'd5
  } mcyc_e;

  typedef enum logic [CLS_W-1:0] {
    IC_SIMPLE = 3'd0,
    IC_IMM    = 3'd1,
    IC_PDEC   = 3'd2,
    IC_PUSH   = 3'd3,
    IC_CALL   = 3'd4,
    IC_CCALL  = 3'd5,
    IC_IN     = 3'd6,
    IC_OUT    = 3'd7
  } iclass_e;

  typedef struct packed {
    mcyc_e          kind;
    logic [T_W-1:0] len;
    logic           last;
  } step_t;
endpackage

// File: rtl/mcyc_rst_sync.sv
module mcyc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = sh_q[STAGES-1];
endmodule

// File: rtl/mcyc_step_rom.sv
module mcyc_step_rom
  import mcyc_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int TW = T_W
) (
  input  iclass_e       cls,
  input  logic          cond,
  input  logic [IW-1:0] idx,
  output step_t         step
);
  localparam logic [TW-1:0] LEN_FS = TW'(FETCH_SHORT);
  localparam logic [TW-1:0] LEN_FL = TW'(FETCH_LONG);
  localparam logic [TW-1:0] LEN_B  = TW'(BUS_LEN);

  logic long_fetch;

  always_comb begin
    long_fetch = (cls == IC_PDEC) || (cls == IC_PUSH) ||
                 (cls == IC_CALL) || (cls == IC_CCALL);
    step.kind = MC_IDLE;
    step.len  = LEN_B;
    step.last = 1'b1;
    if (idx == '0) begin
      step.kind = MC_OF;
      step.len  = long_fetch ? LEN_FL : LEN_FS;
      step.last = (cls == IC_SIMPLE) || (cls == IC_PDEC);
    end else begin
      case (cls)
        IC_IMM: begin
          if (int'(idx) == 1) begin
            step.kind = MC_MR;
            step.last = 1'b1;
          end
        end
        IC_PUSH: begin
          if (int'(idx) <= 2) begin
            step.kind = MC_MW;
            step.last = (int'(idx) == 2);
          end
        end
        IC_CALL, IC_CCALL: begin
          if (int'(idx) <= 2) begin
            step.kind = MC_MR;
            step.last = (int'(idx) == 1) && (cls == IC_CCALL) && !cond;
          end else if (int'(idx) <= 4) begin
            step.kind = MC_MW;
            step.last = (int'(idx) == 4);
          end
        end
        IC_IN, IC_OUT: begin
          if (int'(idx) == 1) begin
            step.kind = MC_MR;
            step.last = 1'b0;
          end else if (int'(idx) == 2) begin
            step.kind = (cls == IC_IN) ? MC_IOR : MC_IOW;
            step.last = 1'b1;
          end
        end
        default: begin
          step.kind = MC_IDLE;
          step.last = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/mcyc_strobe.sv
module mcyc_strobe
  import mcyc_pkg::*;
#(
  parameter int TW = T_W
) (
  input  logic          clk,
  input  logic          rst_q,
  input  mcyc_e         kind,
  input  logic [TW-1:0] tst,
  output logic          io_m,
  output logic          rd_n,
  output logic          wr_n
);
  logic mid_t;
  logic rd_kind;
  logic wr_kind;

  always_comb begin
    mid_t   = (int'(tst) == 2) || (int'(tst) == 3);
    rd_kind = (kind == MC_OF) || (kind == MC_MR) || (kind == MC_IOR);
    wr_kind = (kind == MC_MW) || (kind == MC_IOW);
    io_m    = (kind == MC_IOR) || (kind == MC_IOW);
    rd_n    = !(rd_kind && mid_t);
    wr_n    = !(wr_kind && mid_t);
  end

  // R8: strobes never overlap
  p_rw_excl_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !(!rd_n && !wr_n));
  // R8: no strobe in T1
  p_no_strobe_t1_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (!rd_n || !wr_n) |-> (int'(tst) != 1));
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
  import mcyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CLS_W-1:0] instr_cls,
  input  logic             cond,
  output logic [KIND_W-1:0] mcyc_type,
  output logic [T_W-1:0]   tstate,
  output logic             io_m,
  output logic             rd_n,
  output logic             wr_n,
  output logic             done,
  output logic             busy
);
  logic             rst_q;
  logic             act_q, act_d;
  iclass_e          cls_q, cls_d;
  logic             cond_q, cond_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [T_W-1:0]   t_q, t_d;
  logic             ce;
  logic             mc_end;
  logic             fin;
  step_t            step;
  mcyc_e            kind_o;

  mcyc_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  mcyc_step_rom #(.IW(IDX_W), .TW(T_W)) u_rom (
    .cls  (cls_q),
    .cond (cond_q),
    .idx  (idx_q),
    .step (step)
  );

  always_comb begin
    mc_end = act_q && (t_q == step.len);
    fin    = mc_end && step.last;
    ce     = act_q || start;
    act_d  = act_q;
    cls_d  = cls_q;
    cond_d = cond_q;
    idx_d  = idx_q;
    t_d    = t_q;
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        cls_d  = iclass_e'(instr_cls);
        cond_d = cond;
        idx_d  = '0;
        t_d    = T_W'(1);
      end
    end else if (fin) begin
      act_d = 1'b0;
      idx_d = '0;
      t_d   = '0;
    end else if (mc_end) begin
      idx_d = idx_q + IDX_W'(1);
      t_d   = T_W'(1);
    end else begin
      t_d   = t_q + T_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      act_q  <= 1'b0;
      cls_q  <= IC_SIMPLE;
      cond_q <= 1'b0;
      idx_q  <= '0;
      t_q    <= '0;
    end else if (ce) begin
      act_q  <= act_d;
      cls_q  <= cls_d;
      cond_q <= cond_d;
      idx_q  <= idx_d;
      t_q    <= t_d;
    end
  end

  assign kind_o = act_q ? step.kind : MC_IDLE;

  mcyc_strobe #(.TW(T_W)) u_strobe (
    .clk   (clk),
    .rst_q (rst_q),
    .kind  (kind_o),
    .tst   (tstate),
    .io_m  (io_m),
    .rd_n  (rd_n),
    .wr_n  (wr_n)
  );

  assign mcyc_type = kind_o;
  assign tstate    = act_q ? t_q : '0;
  assign done      = fin;
  assign busy      = act_q;

  // R10: idle on the clock after done
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> (mcyc_type == MC_IDLE) && !busy);
  // R9: T-state in legal range while busy
  p_t_range_r9: assert property (@(posedge clk) disable iff (!rst_q)
    busy |-> (int'(tstate) >= 1) && (int'(tstate) <= FETCH_LONG));
  // R9: count up by one within a cycle
  p_t_step_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (busy && int'(tstate) != 1) |-> (tstate == $past(tstate) + T_W'(1)));
  // R9: cycle type constant inside a machine cycle
  p_kind_hold_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (busy && int'(tstate) != 1) |-> $stable(mcyc_type));
  // R2: an accepted start leads to fetch T1
  p_start_fetch_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (!busy && start) |=> (mcyc_type == MC_OF) && (int'(tstate) == 1));
  // R7: status line only in I/O cycles
  p_iom_r7: assert property (@(posedge clk) disable iff (!rst_q)
    io_m |-> (mcyc_type == MC_IOR) || (mcyc_type == MC_IOW));
endmodule

// File: tb/test_mcyc_seq.sv
`timescale 1ns/1ps
module test_mcyc_seq;
  logic       clk;
  logic       rst_n;
  logic       start;
  logic [2:0] instr_cls;
  logic       cond;
  logic [2:0] mcyc_type;
  logic [2:0] tstate;
  logic       io_m, rd_n, wr_n, done, busy;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 0;

  mcyc_seq i_mcyc_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_cls(instr_cls),
    .cond(cond), .mcyc_type(mcyc_type), .tstate(tstate), .io_m(io_m),
    .rd_n(rd_n), .wr_n(wr_n), .done(done), .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int n_mc(input int c, input int cd);
    case (c)
      0, 2: return 1;
      1:    return 2;
      3, 6, 7: return 3;
      4:    return 5;
      default: return cd ? 5 : 2;
    endcase
  endfunction

  function automatic int kind_of(input int c, input int m);
    if (m == 0) return 1;
    case (c)
      1: return 2;
      3: return 3;
      4, 5: return (m <= 2) ? 2 : 3;
      6: return (m == 1) ? 2 : 4;
      default: return (m == 1) ? 2 : 5;
    endcase
  endfunction

  function automatic int len_of(input int c, input int m);
    if (m != 0) return 3;
    return (c >= 2 && c <= 5) ? 6 : 4;
  endfunction

  function automatic int total_of(input int c, input int cd);
    case (c)
      0: return 4;
      1: return 7;
      2: return 6;
      3: return 12;
      4: return 18;
      5: return cd ? 18 : 9;
      default: return 10;
    endcase
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " R1 type"}, int'(mcyc_type), 0);
    chk({tag, " R1 tstate"}, int'(tstate), 0);
    chk({tag, " R1 io_m"}, int'(io_m), 0);
    chk({tag, " R1 rd_n"}, int'(rd_n), 1);
    chk({tag, " R1 wr_n"}, int'(wr_n), 1);
    chk({tag, " R1 done"}, int'(done), 0);
    chk({tag, " R1 busy"}, int'(busy), 0);
  endtask

  task automatic run_instr(input int c, input int cd);
    int seen;
    int nm;
    seen = 0;
    nm = n_mc(c, cd);
    @(negedge clk);
    start = 1'b1; instr_cls = 3'(c); cond = cd[0];
    for (int m = 0; m < nm; m++) begin
      for (int t = 1; t <= len_of(c, m); t++) begin
        int k;
        bit lastt;
        @(negedge clk);
        k = kind_of(c, m);
        lastt = (m == nm - 1) && (t == len_of(c, m));
        if (m == 0 && t == 1) chk("R2 fetch T1 after start", int'(mcyc_type), 1);
        if (m == 0) chk("R3 fetch type", int'(mcyc_type), k);
        else        chk("R4 cycle type", int'(mcyc_type), k);
        if (m != 0) chk("R9 tstate bus", int'(tstate), t);
        else        chk("R3 tstate fetch", int'(tstate), t);
        if (c == 5) chk("R6 ccall type", int'(mcyc_type), k);
        chk("R7 io_m", int'(io_m), (k == 4 || k == 5) ? 1 : 0);
        chk("R8 rd_n", int'(rd_n),
            ((k == 1 || k == 2 || k == 4) && (t == 2 || t == 3)) ? 0 : 1);
        chk("R8 wr_n", int'(wr_n),
            ((k == 3 || k == 5) && (t == 2 || t == 3)) ? 0 : 1);
        chk("R10 done", int'(done), lastt ? 1 : 0);
        if (mcyc_type != 3'd0) seen++;
        // R10/R6: conflicting inputs during the run must be ignored
        start = !lastt;
        instr_cls = 3'(~c);
        cond = ~cd[0];
      end
    end
    chk("R5 total T-states", seen, total_of(c, cd));
    @(negedge clk);
    check_idle("R10 after done");
    start = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!ended) begin
      ended = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; instr_cls = 3'd0; cond = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("reset held");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("reset released");

    for (int c = 0; c < 8; c++)
      for (int cd = 0; cd < 2; cd++)
        run_instr(c, cd);

    // R11: reset in the middle of a call
    @(negedge clk);
    start = 1'b1; instr_cls = 3'd4; cond = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    chk("R11 busy before reset", int'(busy), 1);
    rst_n = 1'b0;
    #1;
    chk("R11 type after reset", int'(mcyc_type), 0);
    chk("R11 busy after reset", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R11 recovered");
    run_instr(3, 0);

    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule